// File: doc/BRIEF.md
# Sensor Scratchpad Command Engine

This block is the memory-function layer of a single-wire temperature sensor slave. A bus front end turns time slots into strobes and passes them in. Each master write slot arrives as one bit with a strobe. Each master read slot arrives as a request strobe, and the engine answers with one response bit. A separate strobe marks a bus reset. The physical timing, presence detection, ROM-level addressing and the temperature conversion all live elsewhere. The conversion result enters through a load strobe.

The engine holds a nine-byte scratchpad. Two bytes hold the temperature, three bytes are writable by the master (high threshold, low threshold, configuration), three bytes are reserved constants, and the last byte is a check byte. A shadow register set models the non-volatile copy of the three writable bytes. Copying to the shadow and recalling from it each take a programmable number of cycles. While such an operation runs, read slots answer 0, and they answer 1 once it has finished. The shadow is loaded into the scratchpad at power-up.

Top module: `sensor_pad_engine`

## Requirements
- R1: After reset, bytes 0/1 hold TEMP_INIT (low byte first), bytes 2..4 hold NV_INIT (bits 7:0 go to byte 2, bits 15:8 to byte 3, bits 23:16 to byte 4), bytes 5..7 hold RSV_BYTES in the same way, and a read slot answered outside any read command returns 1.
- R2: A tempLoad strobe sets byte 0 to tempValue[7:0] and byte 1 to tempValue[15:8]. Nothing else changes these two bytes.
- R3: Command 4Eh stores the following data bits into bytes 2, 3 and 4 in that order, each byte least significant bit first. Bytes 0, 1 and 5..7 are never written.
- R4: Only bytes received completely are committed. A bus reset in the middle of a data byte discards that byte. Bits after the third data byte are ignored.
- R5: Command BEh answers successive read slots with the 72 scratchpad bits, byte 0 first and each byte least significant bit first. readValid is high, with the bit on readBit, in the cycle after the readReq strobe. Slots after the 72nd bit return 1.
- R6: A read may stop at any point. After a bus reset the next command is accepted normally.
- R7: Byte 8 is the CRC-8 with reflected polynomial 8Ch (x^8+x^5+x^4+1), starting from 0, over bytes 0..7 fed least significant bit first. It tracks changes to those bytes.
- R8: Command 48h copies bytes 2..4 into the shadow at the end of NV_BUSY_CYCLES cycles. Read slots return 0 while this runs and 1 afterwards, and the shadow changes at no other time.
- R9: Command B8h reloads bytes 2..4 from the shadow at the end of NV_BUSY_CYCLES cycles, with the same 0/1 read-slot status as R8.
- R10: After an unrecognised command byte, the engine ignores data bits and answers read slots with 1 until the next bus reset.
- R11: A bus reset arriving while a copy or recall is running is ignored. The operation completes.
- R12: Command bytes are received least significant bit first. The bit-reversed pattern of a valid command, such as 72h, counts as unrecognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, acts as power-up |
| busReset | input | 1 | One-cycle strobe: bus reset seen on the wire |
| bitValid | input | 1 | One-cycle strobe: a master write slot was decoded |
| bitIn | input | 1 | Value of the decoded write slot |
| readReq | input | 1 | One-cycle strobe: master opened a read slot |
| tempLoad | input | 1 | One-cycle strobe: new conversion result available |
| tempValue | input | 16 | Conversion result, low byte to byte 0 |
| readBit | output | 1 | Response bit for the last read slot |
| readValid | output | 1 | High in the cycle after readReq |

## Verification
The bench builds the engine with NV_BUSY_CYCLES set to 20. This keeps copy and recall short enough that a bus reset and several 0-answering read slots fit inside the busy window, and the 1 answer after completion is reached within a few dozen cycles. Non-trivial NV_INIT and RSV_BYTES patterns make every scratchpad byte distinct. As a result, any misplaced byte, reversed bit order or stale check byte changes the read-back stream.

// File: rtl/sensor_pad_pkg.sv
package sensor_pad_pkg;

  localparam int PAD_BITS   = 72;
  localparam int BODY_BITS  = 64;
  localparam int USER_BYTES = 3;
  localparam int IDX_W      = $clog2(PAD_BITS + 1);

  localparam logic [7:0] CMD_WRITE  = 8'h4E;
  localparam logic [7:0] CMD_READ   = 8'hBE;
  localparam logic [7:0] CMD_COPY   = 8'h48;
  localparam logic [7:0] CMD_RECALL = 8'hB8;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_WRITE,
    ST_READ,
    ST_NVBUSY,
    ST_HALT
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic [1:0]       wrSel;
    logic [7:0]       wrData;
    logic             copyDo;
    logic             recallDo;
    logic [IDX_W-1:0] rdIdx;
  } padCtl_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] cur, input logic din);
    logic mix;
    logic [7:0] nxt;
    mix = cur[0] ^ din;
    nxt = {1'b0, cur[7:1]};
    if (mix) nxt = nxt ^ 8'h8C;
    return nxt;
  endfunction

endpackage

// File: rtl/sensor_pad_ctrl.sv
module sensor_pad_ctrl
  import sensor_pad_pkg::*;
#(
  parameter int NV_BUSY_CYCLES = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busReset,
  input  logic    bitValid,
  input  logic    bitIn,
  input  logic    readReq,
  input  logic    padBit,
  output padCtl_t ctl,
  output logic    readBit,
  output logic    readValid
);

  localparam int BUSY_W = $clog2(NV_BUSY_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(NV_BUSY_CYCLES - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(PAD_BITS);

  engState_t         state;
  logic [7:0]        shiftReg;
  logic [2:0]        bitCnt;
  logic [1:0]        byteCnt;
  logic [IDX_W-1:0]  rdPtr;
  logic [BUSY_W-1:0] busyCnt;
  logic              nvIsRecall;

  logic [7:0] nextByte;
  logic       byteDone;

  assign nextByte = {bitIn, shiftReg[7:1]};
  assign byteDone = bitValid && (bitCnt == 3'd7);

  always_comb begin
    ctl          = '0;
    ctl.rdIdx    = rdPtr;
    ctl.wrSel    = byteCnt;
    ctl.wrData   = nextByte;
    if (state == ST_WRITE && byteDone && !busReset) ctl.wrEn = 1'b1;
    if (state == ST_NVBUSY && busyCnt == '0) begin
      ctl.copyDo   = !nvIsRecall;
      ctl.recallDo = nvIsRecall;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_CMD;
      shiftReg   <= '0;
      bitCnt     <= '0;
      byteCnt    <= '0;
      rdPtr      <= '0;
      busyCnt    <= '0;
      nvIsRecall <= 1'b0;
      readBit    <= 1'b1;
      readValid  <= 1'b0;
    end else begin
      readValid <= readReq;
      if (readReq) begin
        case (state)
          ST_READ: begin
            if (rdPtr < LAST_IDX) begin
              readBit <= padBit;
              rdPtr   <= rdPtr + 1'b1;
            end else begin
              readBit <= 1'b1;
            end
          end
          ST_NVBUSY: readBit <= 1'b0;
          default:   readBit <= 1'b1;
        endcase
      end

      if (busReset && state != ST_NVBUSY) begin
        state   <= ST_CMD;
        bitCnt  <= '0;
        byteCnt <= '0;
        rdPtr   <= '0;
      end else begin
        case (state)
          ST_CMD: begin
            if (bitValid) begin
              shiftReg <= nextByte;
              bitCnt   <= bitCnt + 1'b1;
              if (bitCnt == 3'd7) begin
                rdPtr   <= '0;
                byteCnt <= '0;
                case (nextByte)
                  CMD_WRITE: state <= ST_WRITE;
                  CMD_READ:  state <= ST_READ;
                  CMD_COPY: begin
                    state      <= ST_NVBUSY;
                    busyCnt    <= BUSY_LOAD;
                    nvIsRecall <= 1'b0;
                  end
                  CMD_RECALL: begin
                    state      <= ST_NVBUSY;
                    busyCnt    <= BUSY_LOAD;
                    nvIsRecall <= 1'b1;
                  end
                  default: state <= ST_HALT;
                endcase
              end
            end
          end
          ST_WRITE: begin
            if (bitValid) begin
              shiftReg <= nextByte;
              bitCnt   <= bitCnt + 1'b1;
              if (byteDone) begin
                byteCnt <= byteCnt + 1'b1;
                if (byteCnt == 2'(USER_BYTES - 1)) state <= ST_HALT;
              end
            end
          end
          ST_NVBUSY: begin
            if (busyCnt == '0) state <= ST_HALT;
            else               busyCnt <= busyCnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> (ctl.wrSel < 2'(USER_BYTES))); // R3

  AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NVBUSY && readReq) |=> (readValid && !readBit)); // R8

  AST_BUSY_IGNORES_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NVBUSY && busyCnt != '0 && busReset) |=> (state == ST_NVBUSY)); // R11

  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && !busReset) |=> (state == ST_HALT)); // R10

  AST_READ_PAST_END: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && rdPtr == LAST_IDX && readReq && !busReset) |=> (readValid && readBit)); // R5

endmodule

// File: rtl/sensor_pad_dp.sv
module sensor_pad_dp
  import sensor_pad_pkg::*;
#(
  parameter logic [23:0] NV_INIT   = 24'h7F_0A_46,
  parameter logic [23:0] RSV_BYTES = 24'h10_0C_FF,
  parameter logic [15:0] TEMP_INIT = 16'h0550
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tempLoad,
  input  logic [15:0] tempValue,
  input  padCtl_t     ctl,
  output logic        padBit
);

  logic [15:0]              tempReg;
  logic [8*USER_BYTES-1:0]  userFlat;
  logic [8*USER_BYTES-1:0]  shadowReg;
  logic [BODY_BITS-1:0]     bodyFlat;
  logic [7:0]               crcNext;
  logic [7:0]               crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         tempReg <= TEMP_INIT;
    else if (tempLoad) tempReg <= tempValue;
  end

  for (genvar g = 0; g < USER_BYTES; g++) begin : gUser
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        userFlat[8*g +: 8] <= NV_INIT[8*g +: 8];
      else if (ctl.recallDo)
        userFlat[8*g +: 8] <= shadowReg[8*g +: 8];
      else if (ctl.wrEn && ctl.wrSel == 2'(g))
        userFlat[8*g +: 8] <= ctl.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shadowReg <= NV_INIT;
    else if (ctl.copyDo) shadowReg <= userFlat;
  end

  assign bodyFlat = {RSV_BYTES, userFlat, tempReg};

  always_comb begin
    crcNext = '0;
    for (int i = 0; i < BODY_BITS; i++) crcNext = crc8Step(crcNext, bodyFlat[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcReg <= '0;
    else       crcReg <= crcNext;
  end

  always_comb begin
    if (ctl.rdIdx < IDX_W'(BODY_BITS)) padBit = bodyFlat[ctl.rdIdx[5:0]];
    else                               padBit = crcReg[ctl.rdIdx[2:0]];
  end

  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tempLoad |=> $stable(tempReg)); // R2

  AST_COPY_TAKES_USER: assert property (@(posedge clk) disable iff (!rstN)
    ctl.copyDo |=> (shadowReg == $past(userFlat))); // R8

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.copyDo |=> $stable(shadowReg)); // R8

  AST_RECALL_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.recallDo |=> (userFlat == $past(shadowReg))); // R9

endmodule

// File: rtl/sensor_pad_engine.sv
module sensor_pad_engine
  import sensor_pad_pkg::*;
#(
  parameter int          NV_BUSY_CYCLES = 50,
  parameter logic [23:0] NV_INIT        = 24'h7F_0A_46,
  parameter logic [23:0] RSV_BYTES      = 24'h10_0C_FF,
  parameter logic [15:0] TEMP_INIT      = 16'h0550
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReset,
  input  logic        bitValid,
  input  logic        bitIn,
  input  logic        readReq,
  input  logic        tempLoad,
  input  logic [15:0] tempValue,
  output logic        readBit,
  output logic        readValid
);

  padCtl_t ctl;
  logic    padBit;

  sensor_pad_ctrl #(
    .NV_BUSY_CYCLES(NV_BUSY_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReset (busReset),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .readReq  (readReq),
    .padBit   (padBit),
    .ctl      (ctl),
    .readBit  (readBit),
    .readValid(readValid)
  );

  sensor_pad_dp #(
    .NV_INIT  (NV_INIT),
    .RSV_BYTES(RSV_BYTES),
    .TEMP_INIT(TEMP_INIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tempLoad (tempLoad),
    .tempValue(tempValue),
    .ctl      (ctl),
    .padBit   (padBit)
  );

endmodule

// File: tb/sensor_pad_engine_tb.sv
`timescale 1ns/1ps
module sensor_pad_engine_tb;

  localparam int          BUSY    = 20;
  localparam logic [23:0] NVI     = 24'h7F_0A_46;
  localparam logic [23:0] RSV     = 24'h10_0C_FF;
  localparam logic [15:0] TINIT   = 16'h0550;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, bitValid = 1'b0, bitIn = 1'b0, readReq = 1'b0, tempLoad = 1'b0;
  logic [15:0] tempValue = '0;
  logic readBit, readValid;

  always #5 clk = ~clk;

  sensor_pad_engine #(
    .NV_BUSY_CYCLES(BUSY), .NV_INIT(NVI), .RSV_BYTES(RSV), .TEMP_INIT(TINIT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .bitValid(bitValid), .bitIn(bitIn),
    .readReq(readReq), .tempLoad(tempLoad), .tempValue(tempValue),
    .readBit(readBit), .readValid(readValid)
  );

  int runCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;
  logic  expQ[$];
  string tagQ[$];
  logic [7:0] mdl [0:8];
  logic [23:0] mdlShadow;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && readValid) begin
      runCnt++;
      if (expQ.size() == 0) begin
        failCnt++;
        $display("FAIL unexpected read response: actual %0b expected none", readBit);
      end else begin
        logic e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (readBit !== e) begin
          failCnt++;
          $display("FAIL %s: actual %0b expected %0b", t, readBit, e);
        end
      end
    end
  end

  function automatic logic [7:0] mdlCrc();
    logic [7:0] c = '0;
    for (int b = 0; b < 8; b++)
      for (int k = 0; k < 8; k++) begin
        logic m;
        m = c[0] ^ mdl[b][k];
        c = c >> 1;
        if (m) c = c ^ 8'h8C;
      end
    return c;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic sendBit(input logic b);
    bitValid = 1'b1; bitIn = b; tick(); bitValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic pulseReset();
    busReset = 1'b1; tick(); busReset = 1'b0;
  endtask

  task automatic readSlot(input logic e, input string t);
    expQ.push_back(e); tagQ.push_back(t);
    readReq = 1'b1; tick(); readReq = 1'b0; tick(); tick();
  endtask

  task automatic readPad(input int nBits, input string t);
    mdl[8] = mdlCrc();
    for (int i = 0; i < nBits; i++) readSlot(mdl[i/8][i%8], t);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    runCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    mdl[0] = TINIT[7:0];  mdl[1] = TINIT[15:8];
    mdl[2] = NVI[7:0];    mdl[3] = NVI[15:8];  mdl[4] = NVI[23:16];
    mdl[5] = RSV[7:0];    mdl[6] = RSV[15:8];  mdl[7] = RSV[23:16];
    mdlShadow = NVI;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1: idle read slot and power-up contents; R7 check byte; R5 serial order
    readSlot(1'b1, "R1 idle slot");
    pulseReset(); sendByte(8'hBE);
    readPad(72, "R1 R5 R7 power-up pad");
    readSlot(1'b1, "R5 past end");
    readSlot(1'b1, "R5 past end");

    // R2: temperature load
    tempValue = 16'hFE6F; tempLoad = 1'b1; tick(); tempLoad = 1'b0; tick();
    mdl[0] = 8'h6F; mdl[1] = 8'hFE;
    pulseReset(); sendByte(8'hBE);
    readPad(72, "R2 R7 temp load");

    // R3 R4: full write, fourth byte ignored
    pulseReset(); sendByte(8'h4E);
    sendByte(8'h3C); sendByte(8'hC5); sendByte(8'h1F); sendByte(8'hAA);
    mdl[2] = 8'h3C; mdl[3] = 8'hC5; mdl[4] = 8'h1F;
    pulseReset(); sendByte(8'hBE);
    readPad(72, "R3 write three bytes");

    // R4: partial write, R6 early stop
    pulseReset(); sendByte(8'h4E);
    sendByte(8'h81);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    pulseReset();
    mdl[2] = 8'h81;
    sendByte(8'hBE);
    readPad(20, "R6 early stop");
    pulseReset(); sendByte(8'hBE);
    readPad(72, "R4 partial write");

    // R8: copy with busy status, R11 reset during busy
    pulseReset(); sendByte(8'h48);
    readSlot(1'b0, "R8 copy busy");
    pulseReset();
    readSlot(1'b0, "R11 busy after reset");
    repeat (BUSY + 10) tick();
    readSlot(1'b1, "R8 copy done");
    mdlShadow = {mdl[4], mdl[3], mdl[2]};

    // overwrite, then recall (R9)
    pulseReset(); sendByte(8'h4E);
    sendByte(8'h00); sendByte(8'hFF); sendByte(8'h5A);
    mdl[2] = 8'h00; mdl[3] = 8'hFF; mdl[4] = 8'h5A;
    pulseReset(); sendByte(8'hBE);
    readPad(40, "R3 second write");
    pulseReset(); sendByte(8'hB8);
    readSlot(1'b0, "R9 recall busy");
    readSlot(1'b0, "R9 recall busy");
    repeat (BUSY + 10) tick();
    readSlot(1'b1, "R9 recall done");
    mdl[2] = mdlShadow[7:0]; mdl[3] = mdlShadow[15:8]; mdl[4] = mdlShadow[23:16];
    pulseReset(); sendByte(8'hBE);
    readPad(72, "R9 recalled pad");

    // R10 R12: reversed write code is unrecognised
    pulseReset(); sendByte(8'h72);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    readSlot(1'b1, "R10 halted slot");
    sendByte(8'hBE);
    readSlot(1'b1, "R10 command ignored");
    pulseReset(); sendByte(8'hBE);
    readPad(72, "R12 R10 pad unchanged");

    repeat (4) tick();
    if (expQ.size() != 0) begin
      runCnt++; failCnt++;
      $display("FAIL R5 missing responses: actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end

endmodule